// File: doc/BRIEF.md
# SIMD Single-Lane Load Unit

This block carries out a vector load of one element into one lane of a 64-bit vector register. It takes a 32-bit instruction word together with the current base register value, the index register value and the present contents of the destination vector register. It then decodes the element width, the lane and the writeback mode. It checks the optional alignment request and issues one memory read of 1, 2 or 4 bytes over a valid/ready request channel. When the response arrives, the element is merged into the chosen lane, and the rest of the vector register keeps its old bits.

The result comes back with a single-cycle `done` strobe. The strobe carries the merged vector register, its 5-bit register number and, when the writeback mode calls for it, a new base value. The strobe may instead carry an undefined-instruction flag or an alignment-fault flag; in that case nothing is written. Register file storage, condition checks and the memory system are outside the block.

Top module: `simd_lane_load`

## Requirements
- R1: An instruction is accepted only if [31:23] is 111101001 or 111110011, bit 21 is 1, bit 20 is 0 and [9:8] is 00. Any other word finishes with `undef` high, no memory request and no writes.
- R2: The size field at [11:10] selects 1 byte (00), 2 bytes (01) or 4 bytes (10). The read is issued at the base value with `mem_size` equal to that code.
- R3: A size field of 11 finishes with `undef` high, no memory request and no writes.
- R4: The byte offset of the lane within the vector is index_align[3:1] for bytes, {index_align[3:2],0} for halfwords and {index_align[3],00} for words; index_align is bits [7:4]. Only the element's bytes are replaced, taken little-endian from the low bytes of `mem_rsp_data`. All other bytes keep the value of `dreg_in`.
- R5: `dreg_idx` equals {instr[22], instr[15:12]}.
- R6: When Rm (bits [3:0]) is 1111, `base_we` stays low.
- R7: When Rm is 1101, `base_we` is high and `base_out` equals base plus the element size in bytes.
- R8: For any other Rm, `base_we` is high and `base_out` equals base plus `index_val`.
- R9: A halfword with index_align[0]=1 and an odd address faults. A word with index_align[1:0]≠00 and an address not a multiple of 4 faults. Byte loads and loads whose alignment bits are zero never fault. A fault raises `align_fault` with no memory request and no writes.
- R10: `mem_req_valid` and `mem_addr` and `mem_size` hold steady until `mem_req_ready`, and exactly one request is made per load.
- R11: `done` is a one-cycle pulse. `dreg_we`, `base_we`, `align_fault` and `undef` are high only together with `done`.
- R12: `start` is ignored while `busy` is high; the operation in flight completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the operands present this cycle |
| instr | input | 32 | Instruction word |
| base_val | input | XLEN | Base register value |
| index_val | input | XLEN | Index register value |
| dreg_in | input | 64 | Current destination vector register value |
| busy | output | 1 | Operation in flight |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_addr | output | XLEN | Read byte address |
| mem_size | output | 2 | Read size code (00/01/10) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | MEM_W | Read data, little-endian from the low byte |
| done | output | 1 | One-cycle completion strobe |
| dreg_we | output | 1 | Vector register write enable |
| dreg_idx | output | 5 | Vector register number |
| dreg_out | output | 64 | Merged vector register value |
| base_we | output | 1 | Base register write enable |
| base_out | output | XLEN | New base value |
| align_fault | output | 1 | Alignment fault |
| undef | output | 1 | Undefined encoding |

## Verification
The bench builds the block with its defaults, a 32-bit general register width and a 32-bit read data path. At these values every element width fits in one response, and every lane offset of the 64-bit register can be reached. A bench memory model with an adjustable accept delay brings request stalls within reach. Base values are chosen on odd, even and word-misaligned addresses, so that both the enforced and the unenforced alignment paths are exercised.

// File: rtl/sl_pkg.sv
package sl_pkg;
  localparam int VEC_BYTES = 8;
  localparam int OFF_W = $clog2(VEC_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } esize_e;

  typedef enum logic [1:0] {
    WB_NONE  = 2'b00,
    WB_ESIZE = 2'b01,
    WB_INDEX = 2'b10
  } wbmode_e;

  typedef struct packed {
    logic             legal;
    esize_e           size;
    logic [OFF_W-1:0] lane_off;
    logic             align_req;
    logic [4:0]       vreg;
    wbmode_e          wb;
  } dec_t;

  function automatic logic [2:0] esize_bytes(esize_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/sl_decode.sv
module sl_decode
  import sl_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  localparam logic [8:0] SPACE_A = 9'b111101001;
  localparam logic [8:0] SPACE_B = 9'b111110011;

  logic [3:0] ia;
  logic [3:0] rm;
  logic       fixed_ok;
  esize_e     sz;

  assign ia = instr[7:4];
  assign rm = instr[3:0];
  assign sz = esize_e'(instr[11:10]);
  assign fixed_ok = ((instr[31:23] == SPACE_A) || (instr[31:23] == SPACE_B)) &&
                    (instr[21:20] == 2'b10) && (instr[9:8] == 2'b00);

  always_comb begin
    dec.legal = fixed_ok && (sz != SZ_RSVD);
    dec.size  = sz;
    dec.vreg  = {instr[22], instr[15:12]};
    case (sz)
      SZ_BYTE: begin
        dec.lane_off  = ia[3:1];
        dec.align_req = 1'b0;
      end
      SZ_HALF: begin
        dec.lane_off  = {ia[3:2], 1'b0};
        dec.align_req = ia[0];
      end
      default: begin
        dec.lane_off  = {ia[3], 2'b00};
        dec.align_req = |ia[1:0];
      end
    endcase
    if (rm == 4'b1111)      dec.wb = WB_NONE;
    else if (rm == 4'b1101) dec.wb = WB_ESIZE;
    else                    dec.wb = WB_INDEX;
  end
endmodule

// File: rtl/sl_align_chk.sv
module sl_align_chk
  import sl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] addr,
  input  esize_e          size,
  input  logic            align_req,
  output logic            fault
);
  always_comb begin
    fault = 1'b0;
    if (align_req) begin
      case (size)
        SZ_HALF: fault = addr[0];
        SZ_WORD: fault = |addr[1:0];
        default: fault = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sl_lane_merge.sv
module sl_lane_merge
  import sl_pkg::*;
#(
  parameter int MEM_W = 32
) (
  input  logic [8*VEC_BYTES-1:0] vec_in,
  input  logic [OFF_W-1:0]       lane_off,
  input  esize_e                 size,
  input  logic [MEM_W-1:0]       rd_data,
  output logic [8*VEC_BYTES-1:0] vec_out
);
  localparam int MEM_BYTES = MEM_W / 8;

  logic [3:0] eb;
  assign eb = {1'b0, esize_bytes(size)};

  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
    logic [OFF_W:0] rel;
    logic           hit;
    logic [7:0]     src;
    assign rel = OFF_W'(b) - lane_off;
    assign hit = !rel[OFF_W] && ({{(4-OFF_W){1'b0}}, rel[OFF_W-1:0]} < eb);
    always_comb begin
      src = 8'h00;
      for (int k = 0; k < MEM_BYTES; k++) begin
        if (rel[OFF_W-1:0] == OFF_W'(k)) src = rd_data[8*k +: 8];
      end
    end
    assign vec_out[8*b +: 8] = hit ? src : vec_in[8*b +: 8];
  end
endmodule

// File: rtl/sl_wb_calc.sv
module sl_wb_calc
  import sl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] index,
  input  esize_e          size,
  input  wbmode_e         mode,
  output logic [XLEN-1:0] new_base,
  output logic            we
);
  always_comb begin
    case (mode)
      WB_ESIZE: begin
        new_base = base + XLEN'(esize_bytes(size));
        we       = 1'b1;
      end
      WB_INDEX: begin
        new_base = base + index;
        we       = 1'b1;
      end
      default: begin
        new_base = base;
        we       = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/simd_lane_load.sv
module simd_lane_load
  import sl_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int MEM_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [31:0]            instr,
  input  logic [XLEN-1:0]        base_val,
  input  logic [XLEN-1:0]        index_val,
  input  logic [8*VEC_BYTES-1:0] dreg_in,
  output logic                   busy,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [XLEN-1:0]        mem_addr,
  output logic [1:0]             mem_size,
  input  logic                   mem_rsp_valid,
  input  logic [MEM_W-1:0]       mem_rsp_data,
  output logic                   done,
  output logic                   dreg_we,
  output logic [4:0]             dreg_idx,
  output logic [8*VEC_BYTES-1:0] dreg_out,
  output logic                   base_we,
  output logic [XLEN-1:0]        base_out,
  output logic                   align_fault,
  output logic                   undef
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_REQ, S_RSP} state_e;

  state_e                 state;
  logic [31:0]            instr_q;
  logic [XLEN-1:0]        base_q;
  logic [XLEN-1:0]        index_q;
  logic [8*VEC_BYTES-1:0] vec_q;

  dec_t                   dec;
  logic                   mis;
  logic [8*VEC_BYTES-1:0] merged;
  logic [XLEN-1:0]        wb_val;
  logic                   wb_en;

  sl_decode u_dec (.instr(instr_q), .dec(dec));

  sl_align_chk #(.XLEN(XLEN)) u_align (
    .addr(base_q), .size(dec.size), .align_req(dec.align_req), .fault(mis)
  );

  sl_lane_merge #(.MEM_W(MEM_W)) u_merge (
    .vec_in(vec_q), .lane_off(dec.lane_off), .size(dec.size),
    .rd_data(mem_rsp_data), .vec_out(merged)
  );

  sl_wb_calc #(.XLEN(XLEN)) u_wb (
    .base(base_q), .index(index_q), .size(dec.size), .mode(dec.wb),
    .new_base(wb_val), .we(wb_en)
  );

  assign busy          = (state != S_IDLE);
  assign mem_req_valid = (state == S_REQ);
  assign mem_addr      = base_q;
  assign mem_size      = dec.size;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      instr_q     <= '0;
      base_q      <= '0;
      index_q     <= '0;
      vec_q       <= '0;
      done        <= 1'b0;
      dreg_we     <= 1'b0;
      dreg_idx    <= '0;
      dreg_out    <= '0;
      base_we     <= 1'b0;
      base_out    <= '0;
      align_fault <= 1'b0;
      undef       <= 1'b0;
    end else begin
      done        <= 1'b0;
      dreg_we     <= 1'b0;
      base_we     <= 1'b0;
      align_fault <= 1'b0;
      undef       <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            instr_q <= instr;
            base_q  <= base_val;
            index_q <= index_val;
            vec_q   <= dreg_in;
            state   <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (!dec.legal || mis) begin
            done        <= 1'b1;
            undef       <= !dec.legal;
            align_fault <= dec.legal && mis;
            dreg_idx    <= dec.vreg;
            dreg_out    <= vec_q;
            base_out    <= base_q;
            state       <= S_IDLE;
          end else begin
            state <= S_REQ;
          end
        end
        S_REQ: begin
          if (mem_req_ready) state <= S_RSP;
        end
        S_RSP: begin
          if (mem_rsp_valid) begin
            done     <= 1'b1;
            dreg_we  <= 1'b1;
            dreg_idx <= dec.vreg;
            dreg_out <= merged;
            base_we  <= wb_en;
            base_out <= wb_val;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sl_load_chk.sv
module sl_load_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_addr,
  input logic [1:0]      mem_size,
  input logic            done,
  input logic            dreg_we,
  input logic            base_we,
  input logic            align_fault,
  input logic            undef
);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_we_with_done: assert property (@(posedge clk) disable iff (rst)
    (dreg_we || base_we) |-> done);

  a_r9_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (done && !dreg_we && !base_we && !undef));

  a_r3_undef_quiet: assert property (@(posedge clk) disable iff (rst)
    undef |-> (done && !dreg_we && !base_we));

  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_size)));

  a_r12_req_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);
endmodule

bind simd_lane_load sl_load_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_size(mem_size),
  .done(done), .dreg_we(dreg_we), .base_we(base_we),
  .align_fault(align_fault), .undef(undef)
);

// File: tb/simd_lane_load_tb_top.sv
`timescale 1ns/1ps
module simd_lane_load_tb_top;
  localparam int XLEN = 32;
  localparam int MEM_W = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [31:0]      instr = '0;
  logic [XLEN-1:0]  base_val = '0;
  logic [XLEN-1:0]  index_val = '0;
  logic [63:0]      dreg_in = '0;
  logic             busy;
  logic             mem_req_valid;
  logic             mem_req_ready = 1'b0;
  logic [XLEN-1:0]  mem_addr;
  logic [1:0]       mem_size;
  logic             mem_rsp_valid = 1'b0;
  logic [MEM_W-1:0] mem_rsp_data = '0;
  logic             done;
  logic             dreg_we;
  logic [4:0]       dreg_idx;
  logic [63:0]      dreg_out;
  logic             base_we;
  logic [XLEN-1:0]  base_out;
  logic             align_fault;
  logic             undef;

  always #2 clk = ~clk;

  simd_lane_load #(.XLEN(XLEN), .MEM_W(MEM_W)) dut_i (.*);

  int n_tests = 0;
  int n_fail = 0;
  int ready_delay = 0;
  int req_count = 0;
  int wait_cnt = 0;
  logic [XLEN-1:0] seen_addr;
  logic [1:0] seen_size;

  function automatic logic [7:0] mb(logic [XLEN-1:0] a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [31:0] mk(bit t32, bit d, logic [3:0] vd, logic [1:0] sz,
                                     logic [3:0] ia, logic [3:0] rm);
    return {t32 ? 9'b111110011 : 9'b111101001, d, 1'b1, 1'b0, 4'h2, vd, sz, 2'b00, ia, rm};
  endfunction

  function automatic logic [63:0] exp_merge(logic [63:0] v, logic [1:0] sz,
                                            logic [3:0] ia, logic [XLEN-1:0] a);
    int off;
    int eb;
    logic [63:0] r;
    r = v;
    eb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    off = (sz == 2'b00) ? int'(ia[3:1]) : (sz == 2'b01) ? int'(ia[3:2]) * 2 : int'(ia[3]) * 4;
    for (int b = 0; b < 8; b++)
      if (b >= off && b < off + eb) r[8*b +: 8] = mb(a + XLEN'(b - off));
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory model: accepts after ready_delay waiting cycles, answers next cycle.
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_ready) begin
        mem_req_ready = 1'b0;
        req_count++;
        mem_rsp_valid = 1'b1;
        mem_rsp_data = {mb(seen_addr + 3), mb(seen_addr + 2), mb(seen_addr + 1), mb(seen_addr)};
        wait_cnt = 0;
      end else if (mem_req_valid) begin
        if (wait_cnt == 0) begin
          seen_addr = mem_addr;
          seen_size = mem_size;
        end else begin
          chk(mem_addr == seen_addr && mem_size == seen_size, "R10 request hold",
              64'(mem_addr), 64'(seen_addr));
        end
        if (wait_cnt >= ready_delay) mem_req_ready = 1'b1;
        wait_cnt++;
      end
    end
  end

  logic [63:0]     r_dreg;
  logic [XLEN-1:0] r_base;
  logic            r_dwe, r_bwe, r_flt, r_und;
  logic [4:0]      r_idx;

  task automatic run_op(logic [31:0] ins, logic [XLEN-1:0] b, logic [XLEN-1:0] x,
                        logic [63:0] v, bit poke_busy);
    int t;
    req_count = 0;
    @(negedge clk);
    instr = ins; base_val = b; index_val = x; dreg_in = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      instr = mk(0, 0, 4'h0, 2'b10, 4'h0, 4'h0);
      base_val = 32'h0000_0100; index_val = 32'h55; dreg_in = '1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 100) begin
      @(negedge clk);
      t++;
    end
    chk(done, "R11 completion", 64'(done), 64'd1);
    r_dreg = dreg_out; r_base = base_out; r_dwe = dreg_we; r_bwe = base_we;
    r_flt = align_fault; r_und = undef; r_idx = dreg_idx;
    @(negedge clk);
    chk(!done && !dreg_we && !base_we, "R11 single pulse", 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    chk(!done && !mem_req_valid && !busy, "R11 reset state",
        {61'd0, done, mem_req_valid, busy}, 64'd0);
  endtask

  task automatic t_byte_nowb();
    logic [63:0] v = 64'h1122_3344_5566_7788;
    run_op(mk(0, 1, 4'hA, 2'b00, 4'b1011, 4'hF), 32'h40, 32'h9, v, 0);
    chk(r_dreg == exp_merge(v, 2'b00, 4'b1011, 32'h40), "R4 byte lane", r_dreg,
        exp_merge(v, 2'b00, 4'b1011, 32'h40));
    chk(r_dwe && !r_bwe, "R6 no base write", {62'd0, r_dwe, r_bwe}, 64'd2);
    chk(r_idx == 5'd26, "R5 register number", 64'(r_idx), 64'd26);
    chk(req_count == 1, "R2 one read", 64'(req_count), 64'd1);
  endtask

  task automatic t_half_esize();
    logic [63:0] v = 64'hA5A5_5A5A_F0F0_0F0F;
    ready_delay = 3;
    run_op(mk(0, 0, 4'h3, 2'b01, 4'b0101, 4'hD), 32'h52, 32'h0, v, 0);
    ready_delay = 0;
    chk(r_dreg == exp_merge(v, 2'b01, 4'b0101, 32'h52), "R4 half lane aligned", r_dreg,
        exp_merge(v, 2'b01, 4'b0101, 32'h52));
    chk(r_bwe && r_base == 32'h54, "R7 base plus size", 64'(r_base), 64'h54);
    chk(!r_flt && req_count == 1, "R10 stalled request once", 64'(req_count), 64'd1);
    chk(r_idx == 5'd3, "R5 register number low", 64'(r_idx), 64'd3);
  endtask

  task automatic t_word_index();
    logic [63:0] v = 64'h0;
    run_op(mk(0, 0, 4'h1, 2'b10, 4'b1000, 4'h3), 32'h61, 32'h10, v, 0);
    chk(r_dreg == exp_merge(v, 2'b10, 4'b1000, 32'h61), "R9 word unenforced loads", r_dreg,
        exp_merge(v, 2'b10, 4'b1000, 32'h61));
    chk(r_bwe && r_base == 32'h71, "R8 base plus index", 64'(r_base), 64'h71);
  endtask

  task automatic t_faults();
    logic [63:0] v = 64'hDEAD_BEEF_0123_4567;
    run_op(mk(0, 0, 4'h1, 2'b01, 4'b0001, 4'hD), 32'h33, 32'h0, v, 0);
    chk(r_flt && !r_dwe && !r_bwe && !r_und && req_count == 0, "R9 half fault",
        {r_flt, r_dwe, r_bwe, r_und, 60'(req_count)}, {4'b1000, 60'd0});
    chk(r_dreg == v, "R9 vector unchanged", r_dreg, v);
    run_op(mk(0, 0, 4'h1, 2'b10, 4'b0011, 4'h4), 32'h42, 32'h8, v, 0);
    chk(r_flt && !r_bwe && req_count == 0, "R9 word fault",
        {r_flt, r_bwe, 62'(req_count)}, {2'b10, 62'd0});
    run_op(mk(0, 0, 4'h1, 2'b01, 4'b0000, 4'hF), 32'h33, 32'h0, v, 0);
    chk(!r_flt && r_dreg == exp_merge(v, 2'b01, 4'b0000, 32'h33), "R9 half unenforced",
        r_dreg, exp_merge(v, 2'b01, 4'b0000, 32'h33));
  endtask

  task automatic t_undef();
    logic [63:0] v = 64'h0F0F_0F0F_0F0F_0F0F;
    logic [31:0] bad;
    run_op(mk(0, 0, 4'h2, 2'b11, 4'b0000, 4'hD), 32'h40, 32'h0, v, 0);
    chk(r_und && !r_dwe && !r_bwe && req_count == 0, "R3 size 11 undefined",
        {r_und, r_dwe, r_bwe, 61'(req_count)}, {3'b100, 61'd0});
    bad = mk(0, 0, 4'h2, 2'b00, 4'b0000, 4'hD);
    bad[21] = 1'b0;
    run_op(bad, 32'h40, 32'h0, v, 0);
    chk(r_und && !r_dwe && req_count == 0, "R1 bad fixed bit", {r_und, r_dwe, 62'(req_count)},
        {2'b10, 62'd0});
    bad = mk(1, 0, 4'h2, 2'b00, 4'b0000, 4'hD);
    bad[31] = 1'b0;
    run_op(bad, 32'h40, 32'h0, v, 0);
    chk(r_und && req_count == 0, "R1 bad opcode", {r_und, 63'(req_count)}, {1'b1, 63'd0});
    run_op(mk(1, 0, 4'h7, 2'b00, 4'b0001, 4'hD), 32'h47, 32'h0, v, 0);
    chk(!r_und && !r_flt && r_dreg == exp_merge(v, 2'b00, 4'b0001, 32'h47) && r_base == 32'h48,
        "R1 second space byte", r_dreg, exp_merge(v, 2'b00, 4'b0001, 32'h47));
  endtask

  task automatic t_busy_start();
    logic [63:0] v = 64'h7777_6666_5555_4444;
    ready_delay = 2;
    run_op(mk(0, 0, 4'h4, 2'b00, 4'b0110, 4'hD), 32'h81, 32'h0, v, 1);
    ready_delay = 0;
    chk(r_dreg == exp_merge(v, 2'b00, 4'b0110, 32'h81) && r_base == 32'h82 && req_count == 1,
        "R12 start ignored while busy", r_dreg, exp_merge(v, 2'b00, 4'b0110, 32'h81));
    repeat (6) @(negedge clk);
    chk(!busy && !done, "R12 no second operation", {62'd0, busy, done}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_byte_nowb();
    t_half_esize();
    t_word_index();
    t_faults();
    t_undef();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule